// File: doc/BRIEF.md
# Half-Duplex MII Transmitter with Collision Retry

This block is the nibble-wide transmit engine of a 10/100 Ethernet MAC. A frame arrives as a byte stream (valid, ready, last) whose final bytes already carry the frame check sequence. The block stores the whole frame in a local buffer and then drives it onto the media-independent interface. Each burst is a preamble and start delimiter, then the stored bytes, each split into two nibbles with the low nibble first. The transmit enable marks the burst. The whole design runs on the transmit clock, so it behaves the same at 2.5 MHz and at 25 MHz.

In half-duplex operation the block watches carrier sense and collision. Both are first passed through two-flop synchronizers. The block defers until carrier has stayed quiet for an inter-frame gap. If a collision is seen during a burst, it cuts the burst short with a fixed jam pattern. It then waits a truncated binary exponential backoff drawn from an LFSR and replays the buffered frame from the first preamble nibble. After a set number of attempts it drops the frame and raises an abort pulse. In full-duplex operation both carrier sense and collision are ignored.

Top module: `mii_tx_retry`

## Requirements
- R1: A burst starts with 15 nibbles of 0x5 and then one nibble of 0xD. mii_tx_en rises with the first of these nibbles and stays high without a break until the last nibble of the burst.
- R2: After the start delimiter, the buffered bytes (including the supplied FCS) are sent in order, low nibble first then high nibble. mii_tx_en falls right after the last high nibble.
- R3: in_ready is high only while the block is collecting a frame. It stays low from the accepted last byte until the frame completes or aborts, so it is never high while mii_tx_en is high.
- R4: An attempt starts only after synchronized carrier sense has been low for IFG_CYCLES (default 24) consecutive clocks. In full-duplex mode the gap is still timed but carrier sense is ignored.
- R5: In half-duplex mode, a synchronized collision during the preamble or data ends that part of the burst. The next JAM_NIBBLES (default 8) nibbles are all 0x5, and then mii_tx_en falls.
- R6: After collision number n, the block waits k slot times of SLOT_CYCLES clocks (default 128), with k drawn from 0 to 2^min(n,10)-1. It then times the inter-frame gap and resends the whole frame from its first preamble nibble.
- R7: A frame is attempted at most MAX_ATTEMPTS (default 16) times. A collision on the last attempt gives a one-clock done_abort pulse, no further burst for that frame, and in_ready high again.
- R8: A frame sent without collision gives a one-clock done_ok pulse after its last nibble. done_ok and done_abort are never high together.
- R9: In full-duplex mode (full_duplex = 1), mii_col and mii_crs have no effect: no jam, no retry, and the frame is sent whole.
- R10: During and after reset, mii_tx_en is low, mii_txd is 0, in_ready is high and neither done pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock (2.5 or 25 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full duplex, carrier and collision ignored |
| in_data | input | 8 | Frame byte from the stream source |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte is the last of the frame |
| in_ready | output | 1 | Block accepts a byte this clock |
| mii_crs | input | 1 | Carrier sense, asynchronous |
| mii_col | input | 1 | Collision, asynchronous |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| done_ok | output | 1 | One-clock pulse: frame sent |
| done_abort | output | 1 | One-clock pulse: frame dropped after too many collisions |

## Verification
The assertions assume that full_duplex only changes while no frame is in flight. They also assume the stream source never offers more than BUF_DEPTH bytes per frame. The bench changes the duplex mode only after a frame has finished, and it limits every frame to well under the buffer depth. Collision and carrier changes are driven on the falling clock edge and held for whole cycles, so each one always passes through the synchronizer. The bench shortens the slot time by parameter so that a run of sixteen collisions stays short, and it checks the backoff gaps against the window that the shortened slot implies.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_GAP,
    ST_SEND,
    ST_JAM,
    ST_WAIT
  } tx_state_e;

  localparam logic [3:0] NIB_PRE = 4'h5;
  localparam logic [3:0] NIB_SFD = 4'hD;
  localparam logic [3:0] NIB_JAM = 4'h5;
endpackage

// File: rtl/mii_sync2.sv
module mii_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mii_frame_buf.sv
module mii_frame_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mii_backoff.sv
module mii_backoff #(
  parameter int          SLOT_CYCLES = 128,
  parameter int          CAP         = 10,
  parameter int          NUM_W       = 5,
  parameter logic [15:0] SEED        = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] coll_num,
  output logic             done
);
  localparam int SLOT_W = $clog2(SLOT_CYCLES);

  logic [15:0]       lfsr_q;
  logic [CAP-1:0]    k_q, mask_q, mask_c;
  logic [SLOT_W-1:0] slot_q;
  logic              run_q;

  // window mask: 2^min(n,CAP)-1
  always_comb begin
    for (int i = 0; i < CAP; i++) mask_c[i] = (int'(coll_num) > i);
  end

  // free-running Galois LFSR
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      k_q    <= '0;
      mask_q <= '0;
      slot_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      k_q    <= lfsr_q[CAP-1:0] & mask_c;
      mask_q <= mask_c;
      slot_q <= '0;
    end else if (run_q) begin
      if (k_q == '0) begin
        run_q <= 1'b0;
      end else if (slot_q == SLOT_W'(SLOT_CYCLES - 1)) begin
        slot_q <= '0;
        k_q    <= k_q - 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign done = run_q && (k_q == '0);

  assert_backoff_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((k_q & ~mask_q) == '0));
endmodule

// File: rtl/mii_tx_retry.sv
module mii_tx_retry
  import mii_tx_pkg::*;
#(
  parameter int BUF_DEPTH    = 64,
  parameter int MAX_ATTEMPTS = 16,
  parameter int JAM_NIBBLES  = 8,
  parameter int SLOT_CYCLES  = 128,
  parameter int IFG_CYCLES   = 24,
  parameter int BACKOFF_CAP  = 10,
  parameter int PRE_BYTES    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       mii_crs,
  input  logic       mii_col,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       done_ok,
  output logic       done_abort
);
  localparam int AW       = $clog2(BUF_DEPTH);
  localparam int LEN_W    = $clog2(BUF_DEPTH + 1);
  localparam int PRE_NIBS = 2 * (PRE_BYTES + 1);
  localparam int NIB_W    = $clog2(PRE_NIBS + 2 * BUF_DEPTH + 1);
  localparam int ATT_W    = $clog2(MAX_ATTEMPTS);
  localparam int JAM_W    = $clog2(JAM_NIBBLES + 1);
  localparam int IFG_W    = $clog2(IFG_CYCLES + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  logic crs_s, col_s;
  mii_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d    ({mii_crs, mii_col}),
    .q    ({crs_s, col_s})
  );

  tx_state_e        state_q, state_d;
  logic [LEN_W-1:0] wr_q, wr_d, len_q, len_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic [ATT_W-1:0] att_q, att_d;
  logic [JAM_W-1:0] jam_q, jam_d;
  logic [IFG_W-1:0] gap_q, gap_d;
  logic             ok_q, ok_d, abort_q, abort_d;
  logic             bo_start, bo_done;

  logic             busy_c, hit_c, accept, room;
  logic [NIB_W-1:0] data_idx, last_nib;
  logic [7:0]       rd_byte;
  logic [3:0]       txd_c;

  assign busy_c   = crs_s & ~full_duplex;
  assign hit_c    = col_s & ~full_duplex;
  assign in_ready = (state_q == ST_LOAD);
  assign accept   = in_valid & in_ready;
  assign room     = (wr_q < LEN_W'(BUF_DEPTH));
  assign data_idx = nib_q - NIB_W'(PRE_NIBS);
  assign last_nib = NIB_W'(PRE_NIBS) + NIB_W'({len_q, 1'b0}) - 1'b1;

  mii_frame_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk  (clk),
    .we   (accept & room),
    .waddr(wr_q[AW-1:0]),
    .wdata(in_data),
    .raddr(AW'(data_idx >> 1)),
    .rdata(rd_byte)
  );

  mii_backoff #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .CAP        (BACKOFF_CAP),
    .NUM_W      (ATT_W + 1)
  ) u_backoff (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (bo_start),
    .coll_num({1'b0, att_q} + 1'b1),
    .done    (bo_done)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    wr_d     = wr_q;
    len_d    = len_q;
    nib_d    = nib_q;
    att_d    = att_q;
    jam_d    = jam_q;
    gap_d    = gap_q;
    ok_d     = 1'b0;
    abort_d  = 1'b0;
    bo_start = 1'b0;
    unique case (state_q)
      ST_LOAD: begin
        if (accept) begin
          if (room) wr_d = wr_q + 1'b1;
          if (in_last) begin
            len_d   = room ? wr_q + 1'b1 : LEN_W'(BUF_DEPTH);
            wr_d    = '0;
            att_d   = '0;
            gap_d   = '0;
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (busy_c) begin
          gap_d = '0;
        end else if (gap_q == IFG_W'(IFG_CYCLES - 1)) begin
          gap_d   = '0;
          nib_d   = '0;
          state_d = ST_SEND;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      ST_SEND: begin
        if (hit_c) begin
          jam_d   = '0;
          state_d = ST_JAM;
        end else if (nib_q == last_nib) begin
          ok_d    = 1'b1;
          state_d = ST_LOAD;
        end else begin
          nib_d = nib_q + 1'b1;
        end
      end
      ST_JAM: begin
        if (jam_q == JAM_W'(JAM_NIBBLES - 1)) begin
          if (att_q == ATT_W'(MAX_ATTEMPTS - 1)) begin
            abort_d = 1'b1;
            state_d = ST_LOAD;
          end else begin
            att_d    = att_q + 1'b1;
            bo_start = 1'b1;
            state_d  = ST_WAIT;
          end
        end else begin
          jam_d = jam_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (bo_done) begin
          gap_d   = '0;
          state_d = ST_GAP;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_LOAD;
      wr_q    <= '0;
      len_q   <= '0;
      nib_q   <= '0;
      att_q   <= '0;
      jam_q   <= '0;
      gap_q   <= '0;
      ok_q    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      len_q   <= len_d;
      nib_q   <= nib_d;
      att_q   <= att_d;
      jam_q   <= jam_d;
      gap_q   <= gap_d;
      ok_q    <= ok_d;
      abort_q <= abort_d;
    end
  end

  // nibble select
  always_comb begin
    txd_c = 4'h0;
    if (state_q == ST_SEND) begin
      if (nib_q < NIB_W'(PRE_NIBS - 1))       txd_c = NIB_PRE;
      else if (nib_q == NIB_W'(PRE_NIBS - 1)) txd_c = NIB_SFD;
      else                                    txd_c = data_idx[0] ? rd_byte[7:4] : rd_byte[3:0];
    end else if (state_q == ST_JAM) begin
      txd_c = NIB_JAM;
    end
  end

  assign mii_txd    = txd_c;
  assign mii_tx_en  = (state_q == ST_SEND) || (state_q == ST_JAM);
  assign done_ok    = ok_q;
  assign done_abort = abort_q;

  assert_no_load_while_tx_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    mii_tx_en |-> !in_ready);

  assert_start_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(mii_tx_en) |-> ($past(gap_q) == IFG_W'(IFG_CYCLES - 1)) && !$past(busy_c));

  assert_jam_length_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(state_q == ST_JAM) |-> ($past(jam_q) == JAM_W'(JAM_NIBBLES - 1)));

  assert_abort_last_try_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    done_abort |-> ($past(att_q) == ATT_W'(MAX_ATTEMPTS - 1)));

  assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(done_ok && done_abort));

  assert_fd_no_jam_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_SEND && full_duplex) |=> (state_q != ST_JAM));
endmodule

// File: tb/test_mii_tx_retry.sv
module test_mii_tx_retry;
  localparam int SLOT = 8;
  localparam int IFG  = 24;
  localparam int NB   = 64;
  localparam int NL   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready;
  logic mii_crs = 1'b0, mii_col = 1'b0;
  logic [3:0] mii_txd;
  logic mii_tx_en, done_ok, done_abort;

  mii_tx_retry #(.SLOT_CYCLES(SLOT), .IFG_CYCLES(IFG)) i_mii_tx_retry (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .mii_crs(mii_crs), .mii_col(mii_col),
    .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
    .done_ok(done_ok), .done_abort(done_abort)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [7:0] fr [0:63];
  int flen = 0;

  // burst monitor
  int nb = 0, cur = 0, ok_cnt = 0, ab_cnt = 0, rdy_viol = 0;
  bit in_burst = 0;
  int blen [0:NB-1];
  int bstart [0:NB-1];
  int bend [0:NB-1];
  logic [3:0] bnib [0:NB-1][0:NL-1];

  always @(negedge clk) begin
    if (mii_tx_en) begin
      if (!in_burst) begin
        in_burst = 1;
        cur = 0;
        if (nb < NB) bstart[nb] = cyc;
      end
      if (nb < NB && cur < NL) bnib[nb][cur] = mii_txd;
      cur++;
      if (in_ready) rdy_viol++;
    end else if (in_burst) begin
      in_burst = 0;
      if (nb < NB) begin
        blen[nb] = cur;
        bend[nb] = cyc;
      end
      nb++;
    end
    if (done_ok) ok_cnt++;
    if (done_abort) ab_cnt++;
  end

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nib(input int i);
    if (i < 15) return 4'h5;
    if (i == 15) return 4'hD;
    return ((i - 16) % 2) ? fr[(i - 16) / 2][7:4] : fr[(i - 16) / 2][3:0];
  endfunction

  function automatic int exp_len();
    return 16 + 2 * flen;
  endfunction

  task automatic load_frame(input int n, input int seed);
    flen = n;
    for (int i = 0; i < n; i++) fr[i] = 8'((seed * 7 + i * 29 + i * i) & 255);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_data = fr[i]; in_valid = 1'b1; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_done();
    int o, a;
    o = ok_cnt; a = ab_cnt;
    while (ok_cnt == o && ab_cnt == a) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_full_burst(input int b, input string req);
    int bad = 0;
    if (blen[b] != exp_len()) bad = 1;
    else for (int i = 0; i < exp_len(); i++) if (bnib[b][i] !== exp_nib(i)) bad++;
    chk(bad == 0, req, "burst length/content (len shown)", blen[b], exp_len());
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(mii_tx_en == 0 && mii_txd == 0, "R10", "tx idle in reset", int'(mii_tx_en), 0);
    chk(in_ready == 1 && !done_ok && !done_abort, "R10", "ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mii_tx_en == 0 && in_ready == 1 && nb == 0, "R10", "idle after reset", nb, 0);
  endtask

  task automatic t_fd_frame();
    int b0 = nb, o = ok_cnt;
    full_duplex = 1'b1;
    load_frame(20, 3);
    chk(in_ready == 0, "R3", "ready low after last byte", int'(in_ready), 0);
    wait_done();
    chk(nb == b0 + 1, "R1", "single burst", nb - b0, 1);
    chk_full_burst(b0, "R1 R2");
    chk(ok_cnt == o + 1 && ab_cnt == 0, "R8", "done_ok pulse count", ok_cnt - o, 1);
    chk(rdy_viol == 0 && in_ready == 1, "R3", "ready while transmitting", rdy_viol, 0);
  endtask

  task automatic t_crs_defer();
    int b0 = nb, t0, d;
    full_duplex = 1'b0;
    mii_crs = 1'b1;
    load_frame(5, 11);
    repeat (60) @(negedge clk);
    chk(nb == b0 && !mii_tx_en, "R4", "deferred while carrier", nb - b0, 0);
    t0 = cyc;
    mii_crs = 1'b0;
    wait_done();
    d = bstart[b0] - t0;
    chk(d >= IFG && d <= IFG + 5, "R4", "start delay after carrier drop", d, IFG + 2);
    chk_full_burst(b0, "R4");
  endtask

  task automatic t_fd_ignores();
    int b0 = nb, o = ok_cnt;
    full_duplex = 1'b1;
    mii_crs = 1'b1; mii_col = 1'b1;
    load_frame(8, 5);
    wait_done();
    mii_crs = 1'b0; mii_col = 1'b0;
    chk(nb == b0 + 1 && ok_cnt == o + 1, "R9", "one burst, success", nb - b0, 1);
    chk_full_burst(b0, "R9");
  endtask

  task automatic t_one_collision();
    int b0 = nb, o = ok_cnt, lp, bad = 0, gap;
    full_duplex = 1'b0;
    load_frame(30, 9);
    while (!mii_tx_en) @(negedge clk);
    repeat (30) @(negedge clk);
    mii_col = 1'b1;
    repeat (2) @(negedge clk);
    mii_col = 1'b0;
    wait_done();
    chk(nb == b0 + 2, "R5", "two bursts", nb - b0, 2);
    lp = blen[b0] - 8;
    chk(lp >= 30 && lp < exp_len(), "R5", "data cut before end", lp, 30);
    for (int i = 0; i < blen[b0]; i++)
      if (bnib[b0][i] !== ((i < lp) ? exp_nib(i) : 4'h5)) bad++;
    chk(bad == 0, "R5", "prefix then 8 jam nibbles of 0x5", bad, 0);
    chk_full_burst(b0 + 1, "R6");
    gap = bstart[b0 + 1] - bend[b0];
    chk(gap >= IFG && gap <= IFG + SLOT + 6, "R6", "backoff gap n=1", gap, IFG);
    chk(ok_cnt == o + 1, "R8", "ok after retry", ok_cnt - o, 1);
  endtask

  task automatic t_abort();
    int b0 = nb, o = ok_cnt, a = ab_cnt, bad = 0, gbad = 0, gap, e;
    full_duplex = 1'b0;
    mii_col = 1'b1;
    load_frame(4, 2);
    wait_done();
    mii_col = 1'b0;
    repeat (300) @(negedge clk);
    chk(nb == b0 + 16, "R7", "attempt count", nb - b0, 16);
    chk(ab_cnt == a + 1 && ok_cnt == o, "R7", "abort pulse", ab_cnt - a, 1);
    for (int b = b0; b < b0 + 16; b++) begin
      if (blen[b] != 9) bad++;
      for (int i = 0; i < 9; i++) if (bnib[b][i] !== 4'h5) bad++;
    end
    chk(bad == 0, "R5", "each attempt is 1 nibble + jam", bad, 0);
    for (int n = 1; n < 16; n++) begin
      e = (n < 10) ? n : 10;
      gap = bstart[b0 + n] - bend[b0 + n - 1];
      if (gap < IFG || gap > IFG + ((1 << e) - 1) * SLOT + 6) gbad++;
    end
    chk(gbad == 0, "R6", "backoff gaps within window", gbad, 0);
    chk(in_ready == 1 && !mii_tx_en, "R7", "released after abort", int'(in_ready), 1);
    b0 = nb; o = ok_cnt;
    load_frame(3, 21);
    wait_done();
    chk(nb == b0 + 1 && ok_cnt == o + 1, "R7", "next frame after abort", nb - b0, 1);
    chk_full_burst(b0, "R7");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fd_frame();
    t_crs_defer();
    t_fd_ignores();
    t_one_collision();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule